// File: doc/BRIEF.md
# Guarded Single-Precision Equality Compare Unit

This block compares two 32-bit operands read as IEEE single-precision numbers and produces an integer verdict: 32-bit 1 when the values are equal, 32-bit 0 otherwise. The verdict is registered and appears one clock after issue. A guard operand travels with the operands. Only its least significant bit is used. When that bit is clear, the issue has no visible effect.

The block also holds a sticky floating-point exception status register. It collects this unit's own flags together with flag updates from other floating-point units that report in the same cycle. A separate write port replaces the register contents, and that port is the only way to clear a flag. Denormal operands are flushed to a signed zero before the compare, and the flush raises a dedicated flag. A flags-only mode returns, as its result, the flags a compare of the same operands would raise, without touching the status register.

Flag bit positions in the status register and in every flag vector are: bit 0 invalid operation, bit 1 denormal input flushed, bit 2 divide by zero, bit 3 overflow, bit 4 underflow, bit 5 inexact.

Top module: `fp_eq_compare_unit`

## Requirements
- R1: When `issue_i` is high and `guard_i[0]` is 1, `res_o` holds 1 on the next cycle if the operands are numerically equal and 0 if they are not, and `res_valid_o` is high for that one cycle.
- R2: If either operand is a NaN (exponent all ones, fraction nonzero), the result is 0. +infinity equals +infinity, and +infinity does not equal -infinity.
- R3: An operand with a zero exponent and a nonzero fraction is treated as zero of its sign. +0 and -0 compare equal. A committed compare with such an operand sets status bit 1.
- R4: A committed compare with a signalling NaN operand (fraction MSB 0) sets status bit 0. A compare with only quiet NaNs (fraction MSB 1) leaves bit 0 clear.
- R5: When `guard_i[0]` is 0, `res_o` keeps its value, `res_valid_o` stays low and the status register is unaffected by the issue, whatever `guard_i[31:1]` holds.
- R6: With no software write, a status bit that is 1 stays 1.
- R7: Without a software write, the next status value is the OR of the old value, every external unit's update vector (unit k on bits [6k+5:6k] of `ext_upd_i`) and the flags of a committed compare.
- R8: A software write in a cycle sets the status to `sw_wdata_i` on the next cycle, overriding all same-cycle updates.
- R9: A committed issue with `flags_only_i` high writes the zero-extended flags the compare would raise to `res_o` and leaves the status register unchanged.
- R10: After reset, `res_o`, `res_valid_o` and `status_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Operation issued this cycle |
| guard_i | input | 32 | Guard operand; only bit 0 is used |
| flags_only_i | input | 1 | Return flags instead of the compare verdict |
| src_a_i | input | 32 | First operand (single precision) |
| src_b_i | input | 32 | Second operand (single precision) |
| ext_upd_i | input | 12 | Flag updates from two other units, 6 bits each |
| sw_wr_i | input | 1 | Software write of the status register |
| sw_wdata_i | input | 6 | Value for the software write |
| res_valid_o | output | 1 | Destination written this cycle |
| res_o | output | 32 | Destination value |
| status_o | output | 6 | Sticky exception status |

## Verification
Three updates can reach the status register in the same cycle: the unit's own compare flags, the external units' update vectors and a software write. The bench issues a compare with a denormal and a signalling NaN while external units report other flags on top of a preset value, and expects the full OR. It then repeats the collision with a software write in the same cycle and expects exactly the written value, while the compare verdict still arrives. Every pair from a list of special values is swept, and expected verdicts and flags are derived from the operands' exponent and fraction fields.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
   localparam int FLAG_W     = 6;
   localparam int FLG_INVAL  = 0;
   localparam int FLG_FLUSH  = 1;
   localparam int FLG_DIVZ   = 2;
   localparam int FLG_OVF    = 3;
   localparam int FLG_UNF    = 4;
   localparam int FLG_INEX   = 5;

   typedef struct packed {
      logic is_nan;
      logic is_snan;
      logic is_zero;
      logic is_denorm;
   } opclass_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
   import fpcmp_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int MAN_W  = 23,
   parameter bit FTZ_EN = 1'b1,
   localparam int OP_W  = 1 + EXP_W + MAN_W
) (
   input  logic [OP_W-1:0] op_i,
   output opclass_t        cls_o,
   output logic [OP_W-1:0] norm_o
);
   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_max, exp_min, man_nz;

   assign exp_f   = op_i[OP_W-2 -: EXP_W];
   assign man_f   = op_i[MAN_W-1:0];
   assign exp_max = &exp_f;
   assign exp_min = ~|exp_f;
   assign man_nz  = |man_f;

   assign cls_o.is_nan  = exp_max & man_nz;
   assign cls_o.is_snan = exp_max & man_nz & ~man_f[MAN_W-1];

   generate
      if (FTZ_EN) begin : g_flush
         assign cls_o.is_denorm = exp_min & man_nz;
         assign cls_o.is_zero   = exp_min;
         assign norm_o = exp_min ? {op_i[OP_W-1], {(OP_W-1){1'b0}}} : op_i;
      end else begin : g_keep
         assign cls_o.is_denorm = 1'b0;
         assign cls_o.is_zero   = exp_min & ~man_nz;
         assign norm_o = op_i;
      end
   endgenerate
endmodule

// File: rtl/fpcmp_core.sv
module fpcmp_core
   import fpcmp_pkg::*;
#(
   parameter int OP_W = 32
) (
   input  logic [OP_W-1:0]   a_i,
   input  logic [OP_W-1:0]   b_i,
   input  opclass_t          cls_a_i,
   input  opclass_t          cls_b_i,
   output logic              eq_o,
   output logic [FLAG_W-1:0] flags_o
);
   logic any_nan, both_zero;

   assign any_nan   = cls_a_i.is_nan | cls_b_i.is_nan;
   assign both_zero = cls_a_i.is_zero & cls_b_i.is_zero;
   assign eq_o      = ~any_nan & (both_zero | (a_i == b_i));

   always_comb begin
      flags_o            = '0;
      flags_o[FLG_INVAL] = cls_a_i.is_snan | cls_b_i.is_snan;
      flags_o[FLG_FLUSH] = cls_a_i.is_denorm | cls_b_i.is_denorm;
   end
endmodule

// File: rtl/fpcmp_status.sv
module fpcmp_status #(
   parameter int FLAG_W  = 6,
   parameter int NUM_EXT = 2,
   localparam int EXT_W  = FLAG_W * NUM_EXT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              own_en_i,
   input  logic [FLAG_W-1:0] own_upd_i,
   input  logic [EXT_W-1:0]  ext_upd_i,
   input  logic              sw_wr_i,
   input  logic [FLAG_W-1:0] sw_wdata_i,
   output logic [FLAG_W-1:0] status_o
);
   logic [FLAG_W-1:0] ext_or [NUM_EXT+1];
   logic [FLAG_W-1:0] stat_q;

   assign ext_or[0] = '0;
   generate
      for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
         assign ext_or[k+1] = ext_or[k] | ext_upd_i[k*FLAG_W +: FLAG_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat_q <= '0;
      else if (sw_wr_i)
         stat_q <= sw_wdata_i;
      else
         stat_q <= stat_q | ext_or[NUM_EXT] | (own_en_i ? own_upd_i : '0);
   end

   assign status_o = stat_q;
endmodule

// File: rtl/fp_eq_compare_unit.sv
module fp_eq_compare_unit
   import fpcmp_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int MAN_W   = 23,
   parameter int NUM_EXT = 2,
   parameter bit FTZ_EN  = 1'b1,
   localparam int DATA_W = 1 + EXP_W + MAN_W,
   localparam int EXT_W  = FLAG_W * NUM_EXT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic [DATA_W-1:0] guard_i,
   input  logic              flags_only_i,
   input  logic [DATA_W-1:0] src_a_i,
   input  logic [DATA_W-1:0] src_b_i,
   input  logic [EXT_W-1:0]  ext_upd_i,
   input  logic              sw_wr_i,
   input  logic [FLAG_W-1:0] sw_wdata_i,
   output logic              res_valid_o,
   output logic [DATA_W-1:0] res_o,
   output logic [FLAG_W-1:0] status_o
);
   generate
      if (NUM_EXT < 1)      begin : g_bad_ext  $error("NUM_EXT must be at least 1"); end
      if (EXP_W < 2)        begin : g_bad_exp  $error("EXP_W too small"); end
      if (MAN_W < 2)        begin : g_bad_man  $error("MAN_W too small"); end
      if (DATA_W <= FLAG_W) begin : g_bad_data $error("result narrower than flag vector"); end
   endgenerate

   opclass_t          cls_a, cls_b;
   logic [DATA_W-1:0] norm_a, norm_b;
   logic              eq;
   logic [FLAG_W-1:0] cmp_flags;
   logic              commit;
   logic [DATA_W-1:0] res_d, res_q;
   logic              valid_q;
   logic              unused_guard_hi;

   assign unused_guard_hi = |guard_i[DATA_W-1:1];

   fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W), .FTZ_EN(FTZ_EN)) u_cls_a (
      .op_i(src_a_i), .cls_o(cls_a), .norm_o(norm_a));
   fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W), .FTZ_EN(FTZ_EN)) u_cls_b (
      .op_i(src_b_i), .cls_o(cls_b), .norm_o(norm_b));

   fpcmp_core #(.OP_W(DATA_W)) u_core (
      .a_i(norm_a), .b_i(norm_b), .cls_a_i(cls_a), .cls_b_i(cls_b),
      .eq_o(eq), .flags_o(cmp_flags));

   assign commit = issue_i & guard_i[0];
   assign res_d  = flags_only_i ? {{(DATA_W-FLAG_W){1'b0}}, cmp_flags}
                                : {{(DATA_W-1){1'b0}}, eq};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= commit;
         if (commit) res_q <= res_d;
      end
   end

   assign res_o       = res_q;
   assign res_valid_o = valid_q;

   fpcmp_status #(.FLAG_W(FLAG_W), .NUM_EXT(NUM_EXT)) u_status (
      .clk(clk), .rst_n(rst_n),
      .own_en_i(commit & ~flags_only_i), .own_upd_i(cmp_flags),
      .ext_upd_i(ext_upd_i), .sw_wr_i(sw_wr_i), .sw_wdata_i(sw_wdata_i),
      .status_o(status_o));
endmodule

// File: rtl/fpcmp_checker.sv
module fpcmp_checker #(
   parameter int DATA_W  = 32,
   parameter int FLAG_W  = 6,
   parameter int NUM_EXT = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     issue_i,
   input logic                     guard_lsb,
   input logic                     flags_only_i,
   input logic [FLAG_W*NUM_EXT-1:0] ext_upd_i,
   input logic                     sw_wr_i,
   input logic [FLAG_W-1:0]        sw_wdata_i,
   input logic                     res_valid_o,
   input logic [DATA_W-1:0]        res_o,
   input logic [FLAG_W-1:0]        status_o
);
   logic [FLAG_W-1:0] ext_any;
   always_comb begin
      ext_any = '0;
      for (int k = 0; k < NUM_EXT; k++) ext_any |= ext_upd_i[k*FLAG_W +: FLAG_W];
   end

   p_valid_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !guard_lsb) |=> !res_valid_o);

   p_res_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid_o |-> $stable(res_o));

   p_no_flag_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_wr_i && ext_any == '0 && !(issue_i && guard_lsb && !flags_only_i))
      |=> $stable(status_o));

   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_wr_i |=> ((status_o & $past(status_o)) == $past(status_o)));

   p_ext_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_wr_i |=> ((status_o & $past(ext_any)) == $past(ext_any)));

   p_sw_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr_i |=> (status_o == $past(sw_wdata_i)));

   p_flags_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && guard_lsb && flags_only_i) |=> (res_o[DATA_W-1:FLAG_W] == '0));

   p_verdict_bool_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && guard_lsb && !flags_only_i) |=> (res_o[DATA_W-1:1] == '0));
endmodule

bind fp_eq_compare_unit fpcmp_checker #(
   .DATA_W(DATA_W), .FLAG_W(fpcmp_pkg::FLAG_W), .NUM_EXT(NUM_EXT)
) u_fpcmp_checker (
   .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .guard_lsb(guard_i[0]),
   .flags_only_i(flags_only_i), .ext_upd_i(ext_upd_i), .sw_wr_i(sw_wr_i),
   .sw_wdata_i(sw_wdata_i), .res_valid_o(res_valid_o), .res_o(res_o),
   .status_o(status_o));

// File: tb/tb_fp_eq_compare_unit.sv
module tb_fp_eq_compare_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_i = 1'b0;
   logic [31:0] guard_i = '0;
   logic        flags_only_i = 1'b0;
   logic [31:0] src_a_i = '0, src_b_i = '0;
   logic [11:0] ext_upd_i = '0;
   logic        sw_wr_i = 1'b0;
   logic [5:0]  sw_wdata_i = '0;
   logic        res_valid_o;
   logic [31:0] res_o;
   logic [5:0]  status_o;

   int errors = 0;
   int checks = 0;
   logic [31:0] vals [14];

   always #4 clk = ~clk;

   fp_eq_compare_unit dut (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .guard_i(guard_i),
      .flags_only_i(flags_only_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
      .ext_upd_i(ext_upd_i), .sw_wr_i(sw_wr_i), .sw_wdata_i(sw_wdata_i),
      .res_valid_o(res_valid_o), .res_o(res_o), .status_o(status_o));

   function automatic bit is_nan(input logic [31:0] v);
      return (v[30:23] == 8'hff) && (v[22:0] != 0);
   endfunction

   function automatic logic [31:0] ref_eq(input logic [31:0] a, input logic [31:0] b);
      if (is_nan(a) || is_nan(b)) return 32'd0;
      if (a[30:23] == 0 && b[30:23] == 0) return 32'd1;
      return (a == b) ? 32'd1 : 32'd0;
   endfunction

   function automatic logic [5:0] ref_flags(input logic [31:0] a, input logic [31:0] b);
      logic [5:0] f = '0;
      f[0] = (is_nan(a) && !a[22]) || (is_nan(b) && !b[22]);
      f[1] = (a[30:23] == 0 && a[22:0] != 0) || (b[30:23] == 0 && b[22:0] != 0);
      return f;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic op(input logic [31:0] a, input logic [31:0] b, input logic [31:0] g,
                     input bit fo, input logic [11:0] ext, input bit sw, input logic [5:0] wd);
      @(negedge clk);
      issue_i = 1'b1; src_a_i = a; src_b_i = b; guard_i = g; flags_only_i = fo;
      ext_upd_i = ext; sw_wr_i = sw; sw_wdata_i = wd;
      @(negedge clk);
      issue_i = 1'b0; ext_upd_i = '0; sw_wr_i = 1'b0; flags_only_i = 1'b0; guard_i = '0;
   endtask

   task automatic sw_write(input logic [5:0] wd);
      @(negedge clk);
      sw_wr_i = 1'b1; sw_wdata_i = wd;
      @(negedge clk);
      sw_wr_i = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      vals[0]  = 32'h00000000; vals[1]  = 32'h80000000; vals[2]  = 32'h3f800000;
      vals[3]  = 32'hbf800000; vals[4]  = 32'h40400000; vals[5]  = 32'h7f800000;
      vals[6]  = 32'hff800000; vals[7]  = 32'h7fc00000; vals[8]  = 32'hffffffff;
      vals[9]  = 32'h7f800001; vals[10] = 32'hff800100; vals[11] = 32'h00400000;
      vals[12] = 32'h80000001; vals[13] = 32'h7f7fffff;

      repeat (3) @(negedge clk);
      // R10 reset state
      chk(res_o == 0, "R10 res", res_o, 0);
      chk(res_valid_o == 0, "R10 valid", {31'd0, res_valid_o}, 0);
      chk(status_o == 0, "R10 status", {26'd0, status_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 R4: full pair sweep, status cleared before each compare
      for (int i = 0; i < 14; i++) begin
         for (int j = 0; j < 14; j++) begin
            sw_write(6'd0);
            op(vals[i], vals[j], 32'd1, 1'b0, 12'd0, 1'b0, 6'd0);
            chk(res_o == ref_eq(vals[i], vals[j]), "R1/R2/R3 verdict", res_o, ref_eq(vals[i], vals[j]));
            chk(res_valid_o == 1'b1, "R1 valid", {31'd0, res_valid_o}, 1);
            chk(status_o == ref_flags(vals[i], vals[j]), "R3/R4 flags",
                {26'd0, status_o}, {26'd0, ref_flags(vals[i], vals[j])});
         end
      end

      // R2 named corner cases
      op(32'h7f800000, 32'hff800000, 32'd1, 1'b0, 12'd0, 1'b0, 6'd0);
      chk(res_o == 0, "R2 +inf vs -inf", res_o, 0);
      op(32'h7f800000, 32'h7f800000, 32'd1, 1'b0, 12'd0, 1'b0, 6'd0);
      chk(res_o == 1, "R2 +inf vs +inf", res_o, 1);
      // R3 +0 vs -0 and flushed denormal vs -0
      sw_write(6'd0);
      op(32'h00400000, 32'h80000000, 32'd1, 1'b0, 12'd0, 1'b0, 6'd0);
      chk(res_o == 1, "R3 denormal equals -0", res_o, 1);
      chk(status_o == 6'b000010, "R3 flush flag", {26'd0, status_o}, 32'h2);
      // R4 quiet NaN leaves invalid clear
      sw_write(6'd0);
      op(32'h7fc00000, 32'h7fc00000, 32'd1, 1'b0, 12'd0, 1'b0, 6'd0);
      chk(status_o == 0, "R4 quiet NaN no invalid", {26'd0, status_o}, 0);

      // R5 guard clear: result, valid and status untouched
      op(32'h3f800000, 32'h3f800000, 32'd1, 1'b0, 12'd0, 1'b0, 6'd0);
      sw_write(6'd0);
      op(32'h00400000, 32'h7f800001, 32'hfffffffe, 1'b0, 12'd0, 1'b0, 6'd0);
      chk(res_o == 1, "R5 result kept", res_o, 1);
      chk(res_valid_o == 0, "R5 no valid", {31'd0, res_valid_o}, 0);
      chk(status_o == 0, "R5 flags kept", {26'd0, status_o}, 0);
      op(32'h00400000, 32'h7f800001, 32'hfffffffe, 1'b1, 12'd0, 1'b0, 6'd0);
      chk(res_o == 1, "R5 flags-only gated", res_o, 1);

      // R9 flags-only variant
      for (int i = 9; i < 14; i++) begin
         for (int j = 0; j < 14; j += 3) begin
            sw_write(6'd0);
            op(vals[i], vals[j], 32'd1, 1'b1, 12'd0, 1'b0, 6'd0);
            chk(res_o == {26'd0, ref_flags(vals[i], vals[j])}, "R9 flags result",
                res_o, {26'd0, ref_flags(vals[i], vals[j])});
            chk(status_o == 0, "R9 status untouched", {26'd0, status_o}, 0);
         end
      end

      // R7 same-cycle merge: preset overflow, own flush+invalid, ext inexact and divide-by-zero
      sw_write(6'b001000);
      op(32'h00400000, 32'h7f800001, 32'd1, 1'b0, {6'b000100, 6'b100000}, 1'b0, 6'd0);
      chk(status_o == 6'b101111, "R7 OR merge", {26'd0, status_o}, 32'h2f);
      chk(res_o == 0, "R7 verdict alongside merge", res_o, 0);

      // R6 sticky across idle cycles and clean compares
      repeat (5) @(negedge clk);
      op(32'h3f800000, 32'h3f800000, 32'd1, 1'b0, 12'd0, 1'b0, 6'd0);
      chk(status_o == 6'b101111, "R6 sticky", {26'd0, status_o}, 32'h2f);

      // R8 software write wins over own and external updates
      op(32'h00400000, 32'h80000001, 32'd1, 1'b0, 12'hfff, 1'b1, 6'b010000);
      chk(status_o == 6'b010000, "R8 write priority", {26'd0, status_o}, 32'h10);
      chk(res_o == 1, "R8 verdict still written", res_o, 1);
      sw_write(6'd0);
      chk(status_o == 0, "R8 clear", {26'd0, status_o}, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule